// File: doc/BRIEF.md
# Linear Address Generation Unit

This block computes operand addresses for a DSP data path. It holds eight sets of 16-bit registers: a pointer, an offset and a modifier. Each memory access names one set, an addressing mode and the memory space it targets. The unit returns the effective address in the same cycle. On the clock edge that accepts the access, it writes the updated pointer back into the same set.

The unit supports only plain linear arithmetic, selected by a modifier of all ones. Pointer updates wrap modulo 2^16. Predecrement uses the decremented pointer both as the address and as the new pointer value. It costs one extra instruction cycle, so the unit raises a stall request for that access. Predecrement is refused for dual-space accesses and for pointer updates that carry no data move. Refused or unknown requests raise an illegal flag and leave all registers unchanged. A separate load port sets any pointer, offset or modifier register.

Top module: `dsp_agu`

## Requirements
- R1: After reset every pointer and offset register reads 0 and every modifier reads 16'hFFFF.
- R2: A load with `ld_sel` 00 writes the pointer, 01 the offset and 10 the modifier of set `ld_idx`. Code 11 changes nothing.
- R3: Mode 000 (no update) gives the address Rn and leaves Rn unchanged.
- R4: Mode 001 (postincrement by offset) gives the address Rn, then sets Rn to Rn+Nn. For example, R2=16'h3200 and N2=16'h0004 give the address 16'h3200 and leave R2=16'h3204.
- R5: Mode 010 gives the address Rn and then sets Rn to Rn+1. Mode 011 gives the address Rn and then sets Rn to Rn-1.
- R6: Mode 100 (predecrement) gives the address Rn-1 and writes Rn-1 into Rn. `stall` is high during that accepted access and low for every other request.
- R7: Predecrement with space code 100 (dual XY) or 101 (update without data move) raises `illegal`. It writes nothing back and keeps `stall` low.
- R8: Mode codes 101–111 and space codes 110–111 raise `illegal`, and nothing is written back. Space codes 000–011 (P, X, Y, L) accept every defined mode.
- R9: A request to a set whose modifier is not 16'hFFFF raises `illegal`, and nothing is written back.
- R10: All pointer arithmetic wraps modulo 2^16. For example, predecrement of 0 gives 16'hFFFF.
- R11: If a pointer load and an accepted access target the same pointer in one cycle, the loaded value is kept.
- R12: With `acc_valid` low, `stall` and `illegal` stay low and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target: 00 pointer, 01 offset, 10 modifier |
| ld_idx | input | 3 | Register set to load |
| ld_data | input | 16 | Load value |
| acc_valid | input | 1 | Access request |
| acc_mode | input | 3 | Addressing mode code |
| acc_idx | input | 3 | Register set used by the access |
| acc_space | input | 3 | Space tag: 000 P, 001 X, 010 Y, 011 L, 100 XY, 101 none |
| ea | output | 16 | Effective operand address |
| stall | output | 1 | Extra-cycle request |
| illegal | output | 1 | Refused request |

## Verification
The pointers are state that the ports do not show directly. A wrong write-back therefore first appears as a wrong `ea` on the next access to that set. The bench follows every access with a no-update read of the same pointer, so a bad update is seen one cycle later. A wrong legality decision shows at once on `illegal` and `stall`. If it also lets a refused access update the pointer, the follow-up read exposes that too. A wrong modifier or offset value shows as a wrong legality result or a wrong step on the next postincrement.

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic          acc_valid,
  input  logic [2:0]    acc_mode,
  input  logic [IW-1:0] acc_idx,
  input  logic [2:0]    acc_space,
  output logic [AW-1:0] ea,
  output logic          stall,
  output logic          illegal
);

  logic [AW-1:0] r_bank [NREG];
  logic [AW-1:0] n_bank [NREG];
  logic [AW-1:0] m_bank [NREG];
  logic [AW-1:0] cur_r, cur_n, next_r;

  assign cur_r = r_bank[acc_idx];
  assign cur_n = n_bank[acc_idx];

  wire predec     = acc_mode == 3'd4;
  wire bad_mode   = acc_mode > 3'd4;
  wire bad_space  = acc_space > 3'd5;
  wire no_predec  = acc_space == 3'd4 || acc_space == 3'd5;
  wire nonlinear  = m_bank[acc_idx] != {AW{1'b1}};
  wire accept;

  assign illegal = acc_valid && (bad_mode || bad_space || nonlinear || (predec && no_predec));
  assign accept  = acc_valid && !illegal;
  assign stall   = accept && predec;
  assign ea      = predec ? cur_r - 1'b1 : cur_r;

  always_comb begin
    case (acc_mode)
      3'd1:        next_r = cur_r + cur_n;
      3'd2:        next_r = cur_r + 1'b1;
      3'd3, 3'd4:  next_r = cur_r - 1'b1;
      default:     next_r = cur_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        r_bank[i] <= '0;
        n_bank[i] <= '0;
        m_bank[i] <= '1;
      end
    end else begin
      if (accept) r_bank[acc_idx] <= next_r;
      if (ld_en) begin
        case (ld_sel)
          2'd0:    r_bank[ld_idx] <= ld_data;
          2'd1:    n_bank[ld_idx] <= ld_data;
          2'd2:    m_bank[ld_idx] <= ld_data;
          default: ;
        endcase
      end
    end
  end

  wire ld_hit = ld_en && ld_sel == 2'd0 && ld_idx == acc_idx;

  p_no_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && acc_mode == 3'd0 && !ld_hit |=> r_bank[$past(acc_idx)] == $past(ea));

  p_post_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && acc_mode == 3'd1 && !ld_hit |=> r_bank[$past(acc_idx)] == $past(ea) + $past(cur_n));

  p_post_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && acc_mode == 3'd2 && !ld_hit |=> r_bank[$past(acc_idx)] == $past(ea) + 1'b1);

  p_predec_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && predec && !ld_hit |=> r_bank[$past(acc_idx)] == $past(ea));

  p_refused_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !ld_hit |=> r_bank[$past(acc_idx)] == $past(cur_r));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |=> r_bank[$past(ld_idx)] == $past(ld_data));

endmodule

// File: tb/dsp_agu_test.sv
module dsp_agu_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ld_en = 0;
  logic [1:0]  ld_sel = 0;
  logic [2:0]  ld_idx = 0;
  logic [15:0] ld_data = 0;
  logic        acc_valid = 0;
  logic [2:0]  acc_mode = 0;
  logic [2:0]  acc_idx = 0;
  logic [2:0]  acc_space = 0;
  logic [15:0] ea;
  logic        stall, illegal;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] mr [8];
  logic [15:0] mn [8];
  logic [15:0] mm [8];

  dsp_agu uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1; ld_sel = sel; ld_idx = idx; ld_data = d;
    @(posedge clk);
    #1 ld_en = 0;
    case (sel)
      2'd0: mr[idx] = d;
      2'd1: mn[idx] = d;
      2'd2: mm[idx] = d;
      default: ;
    endcase
  endtask

  function automatic bit exp_illegal(input logic [2:0] i, input logic [2:0] m, input logic [2:0] s);
    return m > 4 || s > 5 || mm[i] != 16'hFFFF || (m == 4 && (s == 4 || s == 5));
  endfunction

  task automatic access(input string req, input logic [2:0] i, input logic [2:0] m, input logic [2:0] s);
    bit il;
    logic [15:0] e, nx;
    il = exp_illegal(i, m, s);
    e  = (m == 4) ? mr[i] - 16'd1 : mr[i];
    case (m)
      3'd1: nx = mr[i] + mn[i];
      3'd2: nx = mr[i] + 16'd1;
      3'd3, 3'd4: nx = mr[i] - 16'd1;
      default: nx = mr[i];
    endcase
    @(negedge clk);
    acc_valid = 1; acc_idx = i; acc_mode = m; acc_space = s;
    #2;
    chk({req, " illegal"}, {15'd0, illegal}, {15'd0, il});
    chk({req, " stall"}, {15'd0, stall}, {15'd0, (!il && m == 4)});
    if (!il) chk({req, " ea"}, ea, e);
    @(posedge clk);
    #1 acc_valid = 0;
    if (!il) mr[i] = nx;
  endtask

  task automatic readback(input string req, input logic [2:0] i);
    @(negedge clk);
    acc_valid = 1; acc_idx = i; acc_mode = 0; acc_space = 3'd1;
    #2 chk(req, ea, mr[i]);
    @(posedge clk);
    #1 acc_valid = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mr[i] = 0; mn[i] = 0; mm[i] = 16'hFFFF; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      readback("R1 pointer", 3'(i));
      access("R1 offset", 3'(i), 3'd1, 3'd1);
      readback("R1 offset step", 3'(i));
    end

    // R12 idle request does nothing
    @(negedge clk);
    acc_idx = 3'd5; acc_mode = 3'd4; acc_space = 3'd4;
    #2;
    chk("R12 stall idle", {15'd0, stall}, 16'd0);
    chk("R12 illegal idle", {15'd0, illegal}, 16'd0);
    @(posedge clk);
    readback("R12 no change", 3'd5);

    // R4 worked example
    load(2'd0, 3'd2, 16'h3200);
    load(2'd1, 3'd2, 16'h0004);
    access("R4 example", 3'd2, 3'd1, 3'd1);
    readback("R4 example wb", 3'd2);
    chk("R4 example value", mr[2], 16'h3204);

    // R2 code 11 ignored, offset and modifier loads visible via behaviour
    load(2'd3, 3'd2, 16'hDEAD);
    readback("R2 sel11 ignored", 3'd2);

    // Sweep R3 R5 R6 R7 R8 R10
    for (int i = 0; i < 8; i++)
      for (int m = 0; m < 8; m++)
        for (int s = 0; s < 8; s++) begin
          logic [15:0] rv, nv;
          rv = (s == 0) ? 16'h0000 : (s == 2) ? 16'hFFFF : 16'(i * 16'h2345 + m * 16'h0111 + s);
          nv = (s == 3) ? 16'hFFF0 : 16'(16'h0010 * (i + 1) + m);
          load(2'd0, 3'(i), rv);
          load(2'd1, 3'(i), nv);
          access("R3 R5 R6 R7 R8 R10 sweep", 3'(i), 3'(m), 3'(s));
          readback("R3 R5 R6 R7 R8 R10 writeback", 3'(i));
        end

    // R9 nonlinear modifier
    load(2'd2, 3'd6, 16'h00FF);
    load(2'd0, 3'd6, 16'h1000);
    for (int m = 0; m < 5; m++) access("R9 nonlinear", 3'd6, 3'(m), 3'd1);
    load(2'd2, 3'd6, 16'hFFFF);
    readback("R9 no writeback", 3'd6);
    access("R9 restored linear", 3'd6, 3'd2, 3'd1);
    readback("R9 restored wb", 3'd6);

    // R11 load wins over access write-back
    load(2'd0, 3'd3, 16'h0100);
    load(2'd1, 3'd3, 16'h0020);
    @(negedge clk);
    acc_valid = 1; acc_idx = 3'd3; acc_mode = 3'd1; acc_space = 3'd1;
    ld_en = 1; ld_sel = 2'd0; ld_idx = 3'd3; ld_data = 16'h1234;
    @(posedge clk);
    #1 acc_valid = 0; ld_en = 0;
    mr[3] = 16'h1234;
    readback("R11 load wins", 3'd3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule